// File: doc/BRIEF.md
# Bit-Field Operation Unit

This block executes bit-field instructions on a 32-bit register operand. A field is a run of consecutive bits named by a starting offset and a width from 1 to 32 bits. The offset counts from the most significant bit, and a field that runs past the least significant bit wraps around to the top of the word. The unit can test a field, set it, clear it, or invert it. It can extract the field into a result register, either sign-extended or zero-extended. It can insert the low bits of a source register into the field. It can also scan the field for its first one bit.

The caller presents the destination word, the offset, the width code, the source word and an operation code, and raises a one-cycle strobe. On the next clock the unit presents three things together with a one-cycle done pulse. The first is the modified destination word. The second is a 32-bit result value for the extract and scan operations. The third is a pair of negative and zero flags, computed from the field as it stood before any modification. A new strobe may be raised in every cycle.

Top module: `bitfield_unit`

## Requirements
- R1: After reset, `done`, `dst_out`, `res_out`, `flag_n` and `flag_z` are all zero.
- R2: Each cycle with `start` high produces exactly one cycle with `done` high on the following clock, with that operation's results. A cycle without `start` is followed by a cycle without `done`. Back-to-back strobes are answered in order.
- R3: Offset k names bit 31-k. The field covers offsets `offset` to `offset`+w-1, taken modulo 32, where w is `width` and a `width` of 0 means w=32.
- R4: `flag_n` is the first bit of the field (the bit at `offset`). `flag_z` is 1 when every bit of the field is 0. Both come from the field before the operation modifies it.
- R5: Op 3'd0 (test) leaves `dst_out` equal to `dst_in`, with `res_out` zero.
- R6: Op 3'd1 (set) writes ones to every field bit and leaves all other bits unchanged.
- R7: Op 3'd2 (clear) writes zeros to every field bit and leaves all other bits unchanged.
- R8: Op 3'd3 (change) inverts every field bit and leaves all other bits unchanged.
- R9: Op 3'd4 (signed extract) returns the field right-justified in `res_out`, sign-extended from its first bit, with `dst_out` unchanged.
- R10: Op 3'd5 (unsigned extract) returns the field right-justified in `res_out`, zero-extended, with `dst_out` unchanged.
- R11: Op 3'd6 (insert) copies the low w bits of `src_in` into the field, with the least significant source bit landing at the last field offset. All other bits are unchanged and `res_out` is zero.
- R12: Op 3'd7 (find first one) returns in `res_out` the sum `offset`+i, where i is the index within the field of the first one bit, counted from the field's start. `dst_out` is unchanged.
- R13: When the field holds no one bit, op 3'd7 returns `offset`+w. This value can reach 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation strobe |
| op | input | 3 | Operation code |
| dst_in | input | 32 | Destination word |
| offset | input | 5 | Field offset, counted from bit 31 |
| width | input | 5 | Field width code, 0 means 32 |
| src_in | input | 32 | Source word for insert |
| done | output | 1 | Result valid pulse |
| dst_out | output | 32 | Modified destination word |
| res_out | output | 32 | Extract or scan result |
| flag_n | output | 1 | Negative flag from the original field |
| flag_z | output | 1 | Zero flag from the original field |

## Verification
Two things can fall in the same cycle. The unit presents the registered result of one operation while it captures the next strobe, so a stale or early update would corrupt one of the two. The bench provokes this with long runs of back-to-back strobes. These runs are mixed with idle gaps, and each one uses fresh offsets, widths and operations, including fields that wrap past bit 0. A queue holds the expected outcome computed per bit, and it is popped in order as each `done` appears. A mismatch, a missing pulse or an extra pulse is a failure. Within one operation, flag generation and field modification also coincide: set, clear, change and insert are judged on flags taken from the unmodified field.

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int DW = 32,
  localparam int OW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [DW-1:0] dst_in,
  input  logic [OW-1:0] offset,
  input  logic [OW-1:0] width,
  input  logic [DW-1:0] src_in,
  output logic          done,
  output logic [DW-1:0] dst_out,
  output logic [DW-1:0] res_out,
  output logic          flag_n,
  output logic          flag_z
);
  localparam logic [OW:0] DWC = OW'(0) + (OW+1)'(DW);
  localparam logic [2:0] OP_TST = 3'd0, OP_SET = 3'd1, OP_CLR = 3'd2, OP_CHG = 3'd3,
                         OP_EXS = 3'd4, OP_EXU = 3'd5, OP_INS = 3'd6, OP_FFO = 3'd7;

  logic [OW:0]   wn, sh, ofs, lz;
  logic [DW-1:0] rot, mtop, mask, fld_u, fld_s, ins_top, ins_rot, rot_m, ffo_res;
  logic [DW-1:0] dst_nx, res_nx;

  assign wn   = (width == '0) ? DWC : {1'b0, width};
  assign sh   = DWC - wn;
  assign ofs  = {1'b0, offset};

  assign rot     = (dst_in << ofs) | (dst_in >> (DWC - ofs));
  assign mtop    = ~({DW{1'b1}} >> wn);
  assign mask    = (mtop >> ofs) | (mtop << (DWC - ofs));
  assign fld_u   = rot >> sh;
  assign fld_s   = DW'($signed(rot) >>> sh);
  assign ins_top = src_in << sh;
  assign ins_rot = (ins_top >> ofs) | (ins_top << (DWC - ofs));
  assign rot_m   = rot & mtop;

  always_comb begin
    lz = wn;
    for (int i = 0; i < DW; i++)
      if (rot_m[i]) lz = (OW+1)'(DW - 1 - i);
  end

  assign ffo_res = DW'(ofs) + DW'(lz);

  always_comb begin
    dst_nx = dst_in;
    res_nx = '0;
    case (op)
      OP_SET: dst_nx = dst_in | mask;
      OP_CLR: dst_nx = dst_in & ~mask;
      OP_CHG: dst_nx = dst_in ^ mask;
      OP_INS: dst_nx = (dst_in & ~mask) | (ins_rot & mask);
      OP_EXS: res_nx = fld_s;
      OP_EXU: res_nx = fld_u;
      OP_FFO: res_nx = ffo_res;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      dst_out <= '0;
      res_out <= '0;
      flag_n  <= 1'b0;
      flag_z  <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        dst_out <= dst_nx;
        res_out <= res_nx;
        flag_n  <= rot[DW-1];
        flag_z  <= (rot_m == '0);
      end
    end
  end

  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  assert_test_keeps_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_TST) |=> (dst_out == $past(dst_in)));
  assert_set_only_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_SET) |=> ((dst_out & $past(dst_in)) == $past(dst_in)));
  assert_clear_only_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_CLR) |=> ((dst_out & ~$past(dst_in)) == '0));
  assert_change_flips_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_CHG) |=> ($countones(dst_out ^ $past(dst_in)) == int'($past(wn))));
  assert_extu_fits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_EXU) |=> ((res_out >> $past(wn)) == '0));
  assert_zero_flag_extract_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op == OP_EXU || op == OP_EXS)) |=> (flag_z == (res_out == '0)));
  assert_ffo_bound_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_FFO) |=> (res_out <= DW'($past(ofs)) + DW'($past(wn))));
endmodule

// File: tb/bitfield_unit_bench.sv
module bitfield_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] dst_in = '0, src_in = '0;
  logic [4:0]  offset = '0, width = '0;
  logic        done, flag_n, flag_z;
  logic [31:0] dst_out, res_out;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] dst;
    logic [31:0] res;
    logic        n;
    logic        z;
  } exp_t;

  exp_t sbq[$];
  int vectors = 0, miscompares = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bitfield_unit u_bitfield_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dst_in(dst_in),
    .offset(offset), .width(width), .src_in(src_in), .done(done),
    .dst_out(dst_out), .res_out(res_out), .flag_n(flag_n), .flag_z(flag_z));

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R5";  3'd1: return "R6";  3'd2: return "R7";  3'd3: return "R8";
      3'd4: return "R9";  3'd5: return "R10"; 3'd6: return "R11"; default: return "R12/R13";
    endcase
  endfunction

  function automatic exp_t model(input logic [2:0] o, input logic [31:0] d,
                                 input int off, input int wc, input logic [31:0] s);
    exp_t e;
    int w, p, first;
    logic [31:0] fld;
    w = (wc == 0) ? 32 : wc;
    fld = '0;
    first = -1;
    e.op = o; e.dst = d; e.res = '0;
    for (int i = 0; i < w; i++) begin
      p = 31 - ((off + i) % 32);
      fld[w-1-i] = d[p];
      if (d[p] && first < 0) first = i;
      case (o)
        3'd1: e.dst[p] = 1'b1;
        3'd2: e.dst[p] = 1'b0;
        3'd3: e.dst[p] = ~d[p];
        3'd6: e.dst[p] = s[w-1-i];
        default: ;
      endcase
    end
    e.n = d[31 - off];
    e.z = (fld == '0);
    case (o)
      3'd4: begin
        e.res = fld;
        for (int j = w; j < 32; j++) e.res[j] = e.n;
      end
      3'd5: e.res = fld;
      3'd7: e.res = 32'(off + ((first < 0) ? w : first));
      default: ;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [2:0] o, input logic [31:0] d, input int off,
                       input int wc, input logic [31:0] s);
    @(negedge clk);
    start = 1'b1; op = o; dst_in = d; offset = 5'(off); width = 5'(wc); src_in = s;
    sbq.push_back(model(o, d, off, wc, s));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  task automatic check(input string t, input string what, input logic [31:0] a, input logic [31:0] e);
    vectors++;
    if (a !== e) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, a, e);
    end
  endtask

  initial begin : monitor
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(posedge clk); #1;
      if (done) begin
        if (sbq.size() == 0) check("R2", "unexpected done", 32'd1, 32'd0);
        else begin
          e = sbq.pop_front();
          check(tag_of(e.op), "dst_out", dst_out, e.dst);
          check(tag_of(e.op), "res_out", res_out, e.res);
          check("R4", "flag_n", 32'(flag_n), 32'(e.n));
          check("R4", "flag_z", 32'(flag_z), 32'(e.z));
        end
      end else if (sbq.size() != 0) begin
        check("R2", "missing done", 32'd0, 32'd1);
        void'(sbq.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset done", 32'(done), 32'd0);
    check("R1", "reset dst_out", dst_out, 32'd0);
    check("R1", "reset res_out", res_out, 32'd0);
    check("R1", "reset flags", {30'd0, flag_n, flag_z}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R3 wrap past bit 0, width code 0 = 32, width 1
    drive(3'd5, 32'hF000_000A, 28, 8, 0);
    drive(3'd4, 32'h8000_0001, 31, 2, 0);
    drive(3'd5, 32'hDEAD_BEEF, 7, 0, 0);
    drive(3'd0, 32'h1234_5678, 3, 1, 0);
    idle(2);
    drive(3'd1, 32'h0000_0000, 4, 8, 0);
    drive(3'd2, 32'hFFFF_FFFF, 30, 4, 0);
    drive(3'd3, 32'hA5A5_A5A5, 0, 0, 0);
    drive(3'd6, 32'hFFFF_0000, 12, 8, 32'h0000_00C3);
    drive(3'd6, 32'h0, 28, 8, 32'hFFFF_FF81);
    idle(1);
    drive(3'd7, 32'h0010_0000, 2, 16, 0);
    drive(3'd7, 32'h0000_0000, 31, 0, 0);
    drive(3'd7, 32'h8000_0000, 31, 2, 0);
    drive(3'd7, 32'h0000_0001, 31, 32'd0, 0);
    drive(3'd4, 32'h0000_0000, 5, 5, 0);
    drive(3'd1, 32'h0, 10, 3, 0);
    idle(3);

    for (int k = 0; k < 3000; k++) begin
      drive(3'($urandom), $urandom, int'($urandom_range(31)), int'($urandom_range(31)), $urandom);
      if ($urandom_range(3) == 0) idle(int'($urandom_range(2)) + 1);
    end
    idle(4);
    check("R2", "queue drained", 32'(sbq.size()), 32'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule